// File: doc/BRIEF.md
# Page Access Permission and Fault-Code Unit

This purely combinational unit decides what a single memory access may do to the page it has reached. It takes the page attributes merged across all table levels (user, writable, no-execute) with the protection key held in the leaf entry. It also takes the kind of access (load, store or fetch), the privilege of the requester, and the paging controls:

- write-protect for supervisor writes
- supervisor-execute prevention
- supervisor-access prevention
- no-execute enable
- user-key enable and supervisor-key enable

From these, together with two 32-bit key-rights words, it produces a read/write/execute grant mask. When the access is not allowed, it raises a fault flag and a six-bit page-fault error code.

The unit sits just after a page-table walker. The walker reports a not-present entry or a reserved-bit violation, and this unit folds that report into the same error code. A requester that receives the grant mask may cache it together with the translation. A requester that receives a fault passes the code on to exception delivery.

Top module: `page_perm_unit`

## Requirements
- R1: A walker reserved-bit flag gives a fault with code bit 3 set and bit 0 clear. Otherwise, a walker not-present flag gives a fault whose code starts from zero, so bits 0, 3 and 5 are clear. The reserved-bit flag wins when both are raised.
- R2: A user access to a page whose user attribute is clear is a protection fault, with code bit 0 set and bit 5 clear. This applies whatever the key rights are.
- R3: Read (grant bit 0) is given unless the access is supervisor, supervisor-access prevention is on, and the page is a user page.
- R4: Write (grant bit 1) is given only when read is given and either the writable attribute is set or the access is supervisor with write-protect off.
- R5: Execute (grant bit 2) is given when no-execute is clear, except for a supervisor access to a user page with supervisor-execute prevention on.
- R6: User pages take their key rights from the user rights word when user keys are enabled. Supervisor pages take theirs from the supervisor rights word when supervisor keys are enabled. In every other case the rights are zero and have no effect.
- R7: For key k, bit 2k of the selected word is access-disable and removes read and write. Bit 2k+1 is write-disable and removes write only for a user access or when write-protect is on. Execute is never removed by key rights.
- R8: When key rights deny the requested access, the fault is a key fault with code bits 5 and 0 set. This is checked before the combined mask, and a fetch never gives a key fault.
- R9: When the combined mask lacks the requested right, the fault is a protection fault with code bit 0 set and bit 5 clear.
- R10: Every fault code has bit 1 set for a store, bit 2 for a user access, and bit 4 for a fetch while no-execute enable or supervisor-execute prevention is on. Access kind encoding: 0 load, 1 store, 2 fetch, 3 treated as load.
- R11: While a fault is raised the grant mask is zero. With no fault the code is zero and the mask holds the requested right.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pg_user | input | 1 | Merged user attribute of the page |
| pg_rw | input | 1 | Merged writable attribute |
| pg_nx | input | 1 | Merged no-execute attribute |
| pg_key | input | 4 | Protection key of the leaf entry |
| acc_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 load |
| acc_user | input | 1 | Access made at user privilege |
| ctl_wp | input | 1 | Write-protect for supervisor writes |
| ctl_smep | input | 1 | Supervisor-execute prevention |
| ctl_smap | input | 1 | Supervisor-access prevention |
| ctl_nxe | input | 1 | No-execute enable |
| ctl_ukey_en | input | 1 | User key rights enable |
| ctl_skey_en | input | 1 | Supervisor key rights enable |
| ukey_rights | input | 32 | User key-rights word, two bits per key |
| skey_rights | input | 32 | Supervisor key-rights word, two bits per key |
| walk_notpresent | input | 1 | Walker found a not-present entry |
| walk_rsvd | input | 1 | Walker found a reserved-bit violation |
| grant | output | 3 | Granted rights: bit 0 read, 1 write, 2 execute |
| fault | output | 1 | Access must fault |
| fault_code | output | 6 | Page-fault error code |

## Verification
Directed patterns cover the following, each separating one rule from its neighbours:

- each privilege and page-ownership pairing under every access kind, which separates the user-page check from the supervisor-access and supervisor-execute prevention rules
- write-protect toggled under both privileges
- key rights with access-disable, write-disable and both, on the selected key and on a neighbouring key, which shows that the key index and the selected rights word are decoded correctly
- a disabled enable that carries a fully set rights word, which shows that key rights are ignored in that case
- both walker flags together and each flag alone, which pin down the priority between them

Long runs of pseudo-random vectors then compare every output against a behavioural model on every clock.

// File: rtl/pfu_pkg.sv
package pfu_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_ALT   = 2'd3
  } acc_e;

  localparam int RIGHT_R = 0;
  localparam int RIGHT_W = 1;
  localparam int RIGHT_X = 2;
  localparam int RIGHTS  = 3;

  localparam int EC_W    = 6;
  localparam int EC_PROT = 0;
  localparam int EC_WR   = 1;
  localparam int EC_USR  = 2;
  localparam int EC_RSV  = 3;
  localparam int EC_IF   = 4;
  localparam int EC_KEY  = 5;

  // one-hot of the right the access needs
  function automatic logic [RIGHTS-1:0] need_mask(input acc_e k);
    logic [RIGHTS-1:0] m;
    m = '0;
    case (k)
      ACC_STORE: m[RIGHT_W] = 1'b1;
      ACC_FETCH: m[RIGHT_X] = 1'b1;
      default:   m[RIGHT_R] = 1'b1;
    endcase
    return m;
  endfunction

  // access-type bits added to every fault code
  function automatic logic [EC_W-1:0] kind_bits(input acc_e k, input logic usr,
                                                input logic nxe, input logic smep);
    logic [EC_W-1:0] c;
    c = '0;
    c[EC_USR] = usr;
    c[EC_WR]  = (k == ACC_STORE);
    c[EC_IF]  = (k == ACC_FETCH) && (nxe || smep);
    return c;
  endfunction
endpackage

// File: rtl/pfu_base_rights.sv
module pfu_base_rights
  import pfu_pkg::*;
(
  input  logic              pg_user,
  input  logic              pg_rw,
  input  logic              pg_nx,
  input  logic              acc_user,
  input  logic              ctl_wp,
  input  logic              ctl_smep,
  input  logic              ctl_smap,
  output logic [RIGHTS-1:0] base,
  output logic              owner_viol
);
  logic smap_block;
  logic smep_block;

  always_comb begin
    owner_viol = acc_user && !pg_user;
    smap_block = !acc_user && ctl_smap && pg_user;
    smep_block = !acc_user && ctl_smep && pg_user;
    base[RIGHT_R] = !smap_block;
    base[RIGHT_W] = !smap_block && (pg_rw || (!acc_user && !ctl_wp));
    base[RIGHT_X] = !pg_nx && !smep_block;
  end

  always_comb begin
    p_write_needs_read_r4: assert (!base[RIGHT_W] || base[RIGHT_R]);
    p_nx_blocks_exec_r5:   assert (!pg_nx || !base[RIGHT_X]);
  end
endmodule

// File: rtl/pfu_key_rights.sv
module pfu_key_rights
  import pfu_pkg::*;
#(
  parameter int KEY_W = 4,
  localparam int RIGHTS_W = 2 * (1 << KEY_W)
)(
  input  logic                pg_user,
  input  logic [KEY_W-1:0]    pg_key,
  input  logic                acc_user,
  input  logic                ctl_wp,
  input  logic                ukey_en,
  input  logic                skey_en,
  input  logic [RIGHTS_W-1:0] urights,
  input  logic [RIGHTS_W-1:0] srights,
  output logic                key_active,
  output logic [RIGHTS-1:0]   key_mask
);
  logic [RIGHTS_W-1:0] sel;
  logic [KEY_W:0]      ad_idx;
  logic [KEY_W:0]      wd_idx;
  logic                ad;
  logic                wd;

  always_comb begin
    if (pg_user) sel = ukey_en ? urights : '0;
    else         sel = skey_en ? srights : '0;
    key_active = |sel;
    ad_idx = {pg_key, 1'b0};
    wd_idx = {pg_key, 1'b1};
    ad = sel[ad_idx];
    wd = sel[wd_idx];
    key_mask = '1;
    if (key_active) begin
      if (ad) begin
        key_mask[RIGHT_R] = 1'b0;
        key_mask[RIGHT_W] = 1'b0;
      end else if (wd && (acc_user || ctl_wp)) begin
        key_mask[RIGHT_W] = 1'b0;
      end
    end
  end

  always_comb begin
    p_exec_untouched_r7: assert (key_mask[RIGHT_X]);
    p_idle_all_r6:       assert (key_active || (&key_mask));
  end
endmodule

// File: rtl/pfu_fault_enc.sv
module pfu_fault_enc
  import pfu_pkg::*;
(
  input  logic              walk_notpresent,
  input  logic              walk_rsvd,
  input  logic              owner_viol,
  input  logic [RIGHTS-1:0] base,
  input  logic [RIGHTS-1:0] key_mask,
  input  acc_e              kind,
  input  logic              acc_user,
  input  logic              ctl_nxe,
  input  logic              ctl_smep,
  output logic [RIGHTS-1:0] grant,
  output logic              fault,
  output logic [EC_W-1:0]   fault_code
);
  logic [RIGHTS-1:0] need;
  logic [RIGHTS-1:0] merged;
  logic [EC_W-1:0]   kb;
  logic              key_deny;
  logic              prot_deny;

  always_comb begin
    need      = need_mask(kind);
    kb        = kind_bits(kind, acc_user, ctl_nxe, ctl_smep);
    merged    = base & key_mask;
    key_deny  = (key_mask & need) == '0;
    prot_deny = (merged & need) == '0;
    fault      = 1'b1;
    fault_code = kb;
    grant      = '0;
    if (walk_rsvd) begin
      fault_code[EC_RSV] = 1'b1;
    end else if (walk_notpresent) begin
      fault_code = kb;
    end else if (owner_viol) begin
      fault_code[EC_PROT] = 1'b1;
    end else if (key_deny) begin
      fault_code[EC_PROT] = 1'b1;
      fault_code[EC_KEY]  = 1'b1;
    end else if (prot_deny) begin
      fault_code[EC_PROT] = 1'b1;
    end else begin
      fault      = 1'b0;
      fault_code = '0;
      grant      = merged;
    end
  end

  always_comb begin
    p_fetch_no_key_r8: assert (!(kind == ACC_FETCH && fault_code[EC_KEY]));
    p_key_has_p_r8:    assert (!fault_code[EC_KEY] || fault_code[EC_PROT]);
  end
endmodule

// File: rtl/page_perm_unit.sv
module page_perm_unit
  import pfu_pkg::*;
#(
  parameter int KEY_W = 4,
  localparam int RIGHTS_W = 2 * (1 << KEY_W)
)(
  input  logic                pg_user,
  input  logic                pg_rw,
  input  logic                pg_nx,
  input  logic [KEY_W-1:0]    pg_key,
  input  logic [1:0]          acc_kind,
  input  logic                acc_user,
  input  logic                ctl_wp,
  input  logic                ctl_smep,
  input  logic                ctl_smap,
  input  logic                ctl_nxe,
  input  logic                ctl_ukey_en,
  input  logic                ctl_skey_en,
  input  logic [RIGHTS_W-1:0] ukey_rights,
  input  logic [RIGHTS_W-1:0] skey_rights,
  input  logic                walk_notpresent,
  input  logic                walk_rsvd,
  output logic [2:0]          grant,
  output logic                fault,
  output logic [5:0]          fault_code
);
  acc_e              kind;
  logic [RIGHTS-1:0] base_rights;
  logic              owner_viol;
  logic              key_active;
  logic [RIGHTS-1:0] key_mask;
  logic [RIGHTS-1:0] need;

  assign kind = acc_e'(acc_kind);
  assign need = need_mask(kind);

  pfu_base_rights u_base (
    .pg_user    (pg_user),
    .pg_rw      (pg_rw),
    .pg_nx      (pg_nx),
    .acc_user   (acc_user),
    .ctl_wp     (ctl_wp),
    .ctl_smep   (ctl_smep),
    .ctl_smap   (ctl_smap),
    .base       (base_rights),
    .owner_viol (owner_viol)
  );

  pfu_key_rights #(.KEY_W(KEY_W)) u_key (
    .pg_user    (pg_user),
    .pg_key     (pg_key),
    .acc_user   (acc_user),
    .ctl_wp     (ctl_wp),
    .ukey_en    (ctl_ukey_en),
    .skey_en    (ctl_skey_en),
    .urights    (ukey_rights),
    .srights    (skey_rights),
    .key_active (key_active),
    .key_mask   (key_mask)
  );

  pfu_fault_enc u_enc (
    .walk_notpresent (walk_notpresent),
    .walk_rsvd       (walk_rsvd),
    .owner_viol      (owner_viol),
    .base            (base_rights),
    .key_mask        (key_mask),
    .kind            (kind),
    .acc_user        (acc_user),
    .ctl_nxe         (ctl_nxe),
    .ctl_smep        (ctl_smep),
    .grant           (grant),
    .fault           (fault),
    .fault_code      (fault_code)
  );

  always_comb begin
    p_fault_clears_grant_r11: assert (!fault || grant == '0);
    p_ok_has_need_r11:        assert (fault || ((grant & need) != '0 && fault_code == '0));
    p_rsvd_no_p_r1:           assert (!fault_code[EC_RSV] || !fault_code[EC_PROT]);
    p_owner_faults_r2:        assert (!owner_viol || fault);
    p_keyfault_src_r8:        assert (!fault_code[EC_KEY] || key_active);
    p_if_only_fetch_r10:      assert (!fault_code[EC_IF] || kind == ACC_FETCH);
  end
endmodule

// File: tb/tb_page_perm_unit.sv
`timescale 1ns/1ps
module tb_page_perm_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic pg_user, pg_rw, pg_nx, acc_user;
  logic [3:0] pg_key;
  logic [1:0] acc_kind;
  logic ctl_wp, ctl_smep, ctl_smap, ctl_nxe, ctl_ukey_en, ctl_skey_en;
  logic [31:0] ukey_rights, skey_rights;
  logic walk_notpresent, walk_rsvd;
  logic [2:0] grant;
  logic fault;
  logic [5:0] fault_code;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  page_perm_unit dut (.*);

  // behavioural model
  function automatic void model(output logic [2:0] g, output logic f, output logic [5:0] c);
    int need;
    int acc;
    int kr;
    int kbits;
    bit r, w, x, kread, kwrite;
    acc = int'(acc_kind);
    need = (acc == 1) ? 1 : (acc == 2) ? 2 : 0;
    kbits = 0;
    if (acc == 1) kbits += 2;
    if (acc_user) kbits += 4;
    if (acc == 2 && (ctl_nxe || ctl_smep)) kbits += 16;
    g = 3'b000; f = 1'b1;
    if (walk_rsvd) begin c = 6'(kbits + 8); return; end
    if (walk_notpresent) begin c = 6'(kbits); return; end
    if (acc_user && !pg_user) begin c = 6'(kbits + 1); return; end
    r = !( !acc_user && ctl_smap && pg_user);
    w = r && (pg_rw || (!acc_user && !ctl_wp));
    x = !pg_nx && (acc_user || !(ctl_smep && pg_user));
    kr = 0;
    if (pg_user && ctl_ukey_en) kr = int'(ukey_rights);
    if (!pg_user && ctl_skey_en) kr = int'(skey_rights);
    kread = 1; kwrite = 1;
    if (kr != 0) begin
      if (((kr >> (2 * int'(pg_key))) & 1) != 0) begin kread = 0; kwrite = 0; end
      else if ((((kr >> (2 * int'(pg_key) + 1)) & 1) != 0) && (acc_user || ctl_wp)) kwrite = 0;
    end
    if ((need == 0 && !kread) || (need == 1 && !kwrite)) begin c = 6'(kbits + 33); return; end
    r = r && kread; w = w && kwrite;
    if ((need == 0 && !r) || (need == 1 && !w) || (need == 2 && !x)) begin c = 6'(kbits + 1); return; end
    f = 1'b0; c = 6'd0; g = {x, w, r};
  endfunction

  task automatic compare(input string tag);
    logic [2:0] eg; logic ef; logic [5:0] ec;
    model(eg, ef, ec);
    checks++;
    if (grant !== eg || fault !== ef || fault_code !== ec) begin
      errors++;
      $display("FAIL %s: got grant=%b fault=%b code=%b, expected grant=%b fault=%b code=%b",
               tag, grant, fault, fault_code, eg, ef, ec);
    end
  endtask

  task automatic expect_out(input string tag, input logic [2:0] eg, input logic ef, input logic [5:0] ec);
    checks++;
    if (grant !== eg || fault !== ef || fault_code !== ec) begin
      errors++;
      $display("FAIL %s: got grant=%b fault=%b code=%b, expected grant=%b fault=%b code=%b",
               tag, grant, fault, fault_code, eg, ef, ec);
    end
  endtask

  task automatic clear_in();
    {pg_user, pg_rw, pg_nx, acc_user, ctl_wp, ctl_smep, ctl_smap, ctl_nxe} = '0;
    {ctl_ukey_en, ctl_skey_en, walk_notpresent, walk_rsvd} = '0;
    pg_key = '0; acc_kind = 2'd0; ukey_rights = '0; skey_rights = '0;
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    clear_in();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    settle();
    expect_out("reset R11", 3'b111, 1'b0, 6'd0);

    walk_rsvd = 1; walk_notpresent = 1; acc_kind = 2'd1; settle();
    expect_out("R1 both flags", 3'b000, 1'b1, 6'b001010);
    walk_rsvd = 0; settle();
    expect_out("R1 not present", 3'b000, 1'b1, 6'b000010);

    clear_in(); acc_user = 1; settle();
    expect_out("R2 user on sup page", 3'b000, 1'b1, 6'b000101);

    clear_in(); pg_user = 1; ctl_smap = 1; settle();
    expect_out("R3 smap load", 3'b000, 1'b1, 6'b000001);
    acc_user = 1; pg_rw = 1; settle();
    expect_out("R3 user unaffected", 3'b111, 1'b0, 6'd0);

    clear_in(); ctl_wp = 1; acc_kind = 2'd1; settle();
    expect_out("R4 wp store", 3'b000, 1'b1, 6'b000011);
    ctl_wp = 0; settle();
    expect_out("R4 sup store no wp", 3'b111, 1'b0, 6'd0);

    clear_in(); pg_user = 1; ctl_smep = 1; acc_kind = 2'd2; settle();
    expect_out("R5 smep fetch", 3'b000, 1'b1, 6'b010001);
    clear_in(); pg_nx = 1; acc_kind = 2'd2; settle();
    expect_out("R5 nx fetch", 3'b000, 1'b1, 6'b000001);
    ctl_nxe = 1; settle();
    expect_out("R10 fetch bit", 3'b000, 1'b1, 6'b010001);

    clear_in(); pg_user = 1; acc_user = 1; pg_rw = 1; ukey_rights = '1; settle();
    expect_out("R6 user key disabled", 3'b111, 1'b0, 6'd0);
    ctl_skey_en = 1; skey_rights = '1; settle();
    expect_out("R6 sup word ignored", 3'b111, 1'b0, 6'd0);
    ctl_ukey_en = 1; ukey_rights = 32'h0000_0100; pg_key = 4'd4; settle();
    expect_out("R7 key fault AD", 3'b000, 1'b1, 6'b100101);
    pg_key = 4'd5; settle();
    expect_out("R7 neighbour key", 3'b111, 1'b0, 6'd0);
    pg_key = 4'd4; ukey_rights = 32'h0000_0200; settle();
    expect_out("R7 WD load", 3'b101, 1'b0, 6'd0);
    acc_kind = 2'd1; settle();
    expect_out("R8 WD store key fault", 3'b000, 1'b1, 6'b100111);
    ukey_rights = 32'h0000_0300; acc_kind = 2'd2; settle();
    expect_out("R8 fetch no key fault", 3'b100, 1'b0, 6'd0);
    clear_in(); ctl_skey_en = 1; skey_rights = 32'h0000_0002; acc_kind = 2'd1; settle();
    expect_out("R7 sup WD no wp", 3'b111, 1'b0, 6'd0);
    clear_in(); pg_user = 1; acc_user = 1; acc_kind = 2'd1; settle();
    expect_out("R9 readonly store", 3'b000, 1'b1, 6'b000111);
    acc_kind = 2'd3; settle();
    expect_out("R10 kind 3 as load", 3'b101, 1'b0, 6'd0);

    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      {pg_user, pg_rw, pg_nx, acc_user} = 4'($urandom);
      {ctl_wp, ctl_smep, ctl_smap, ctl_nxe, ctl_ukey_en, ctl_skey_en} = 6'($urandom);
      pg_key = 4'($urandom); acc_kind = 2'($urandom);
      ukey_rights = ($urandom % 4 == 0) ? 32'd0 : $urandom;
      skey_rights = ($urandom % 4 == 0) ? 32'd0 : $urandom;
      walk_notpresent = ($urandom % 8) == 0;
      walk_rsvd = ($urandom % 8) == 0;
      @(posedge clk); #1;
      compare("random R1..R11 model");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule